// File: doc/BRIEF.md
# Range-Based Memory Protection Checker

This block judges every instruction fetch and every data load or store against a table of address windows. Windows come in pairs, and there are separate pairs for data traffic and for code traffic. A small number of protection sets, from two to four, each hold one select flag per pair. The flag picks which window of that pair is live while the set is active. A two-bit field chooses the active set, so software can swap the whole protection picture with one register write.

Data windows grant read and write rights. Code windows grant only execute rights. An access is allowed when at least one live window that covers its address grants the access type. If no live window covers the address, the access is refused. Traffic to the peripheral and emulator segments is never checked, and neither is context save or restore traffic. There is no privilege input, so privileged code is held to the same windows as any other code.

Every access gets its verdict one clock later. A refused access also raises a fault pulse that names the access type. Each type has a sticky status bit that holds the fault until software clears it. All windows, rights, select flags and control fields are reached through a simple word-addressed configuration port.

Top module: `mpu_range_check`

## Requirements
- R1: Window bounds keep 8-byte granularity: bits [2:0] of a written bound are dropped and read back as zero. An address hits a window when lower <= address < upper.
- R2: Control field bits [2:1] choose the active set. A write of a set number >= N_SETS leaves the field unchanged. For pair p, the active set's select flag at 0 makes window 2p live and at 1 makes window 2p+1 live.
- R3: Access kind 0 is read, 1 is write, 2 is execute, and kind 3 is handled exactly as a read. Read and write use only the data windows and their read or write bit. Execute uses only the code windows and their execute bit.
- R4: With protection on, an unexempt access whose address lies in no live window of its class is refused.
- R5: When live windows overlap, the rights granted are the union of their rights.
- R6: An address whose top four bits are 0xF (peripheral) or 0xE (emulator), or any access flagged as context save or restore, is always permitted.
- R7: While the global enable bit (control bit 0) is 0, every access is permitted.
- R8: The verdict appears on the outputs one clock after the access is presented. The fault output pulses only for a valid refused access, and it reports the kind (0 read, 1 write, 2 execute). With no valid access, valid and fault are 0 the next cycle.
- R9: Status bits 0, 1 and 2 record read, write and execute faults and stay set until a 1 is written to them at the status word. A fault in the same cycle as its clear leaves the bit set.
- R10: After reset all outputs are 0, every register reads 0, and protection is off.
- R11: Word map: 0x00 control, 0x01 status, 0x02 data rights (bit 2i read, bit 2i+1 write of data window i), 0x03 code execute bits (bit i for code window i), 0x08+s select flags of set s (data pairs from bit 0, code pairs from bit 8), 0x20+2i/0x21+2i lower/upper of data window i, 0x40+2i/0x41+2i lower/upper of code window i.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| acc_valid | input | 1 | An access is presented this cycle |
| acc_addr | input | AW | Byte address of the access |
| acc_kind | input | 2 | 0 read, 1 write, 2 execute, 3 as read |
| acc_ctx | input | 1 | Access belongs to context save or restore |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 7 | Configuration word index |
| cfg_wdata | input | AW | Configuration write data |
| cfg_rdata | output | AW | Configuration read data for cfg_addr |
| chk_valid | output | 1 | Verdict present |
| chk_permit | output | 1 | Access permitted |
| chk_fault | output | 1 | Access refused |
| chk_fault_kind | output | 2 | Kind of the refused access |

## Verification
Fault capture and a software clear of the status word can land on the same clock edge. To provoke this, the bench pulses a status clear and a refused access in the same cycle. It then requires the bit of the new fault to survive while the cleared older bit drops. The bench also issues a clear that names only one bit while other bits are set, and it expects those other bits to stay set. The permission logic itself is swept over every word address in a 512-byte window, for each access kind and each set. The expected verdicts come from a model built on the windows the bench programmed.

// File: rtl/mpu_pkg.sv
package mpu_pkg;
    localparam int GRAN_BITS = 3;
    localparam int CFG_AW    = 7;

    localparam logic [1:0] KIND_RD  = 2'd0;
    localparam logic [1:0] KIND_WR  = 2'd1;
    localparam logic [1:0] KIND_EX  = 2'd2;
    localparam logic [1:0] KIND_RSV = 2'd3;

    localparam logic [3:0] SEG_PERIPH = 4'hF;
    localparam logic [3:0] SEG_EMU    = 4'hE;

    localparam logic [CFG_AW-1:0] REG_CTRL      = 7'h00;
    localparam logic [CFG_AW-1:0] REG_FSTAT     = 7'h01;
    localparam logic [CFG_AW-1:0] REG_DPERM     = 7'h02;
    localparam logic [CFG_AW-1:0] REG_XPERM     = 7'h03;
    localparam logic [CFG_AW-1:0] REG_SEL_BASE  = 7'h08;
    localparam logic [CFG_AW-1:0] REG_DRNG_BASE = 7'h20;
    localparam logic [CFG_AW-1:0] REG_CRNG_BASE = 7'h40;
endpackage

// File: rtl/mpu_window_cmp.sv
module mpu_window_cmp #(
    parameter int AW = 32
) (
    input  logic [AW-1:0] addr,
    input  logic [AW-1:0] lo,
    input  logic [AW-1:0] hi,
    output logic          hit
);
    // half-open window: lower bound included, upper bound excluded
    assign hit = (addr >= lo) && (addr < hi);
endmodule

// File: rtl/mpu_cfg_regs.sv
module mpu_cfg_regs
    import mpu_pkg::*;
#(
    parameter int AW      = 32,
    parameter int N_DPAIR = 2,
    parameter int N_CPAIR = 2,
    parameter int N_SETS  = 2,
    localparam int ND     = 2 * N_DPAIR,
    localparam int NC     = 2 * N_CPAIR,
    localparam int BW     = AW - GRAN_BITS
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic                              cfg_we,
    input  logic [CFG_AW-1:0]                 cfg_addr,
    input  logic [AW-1:0]                     cfg_wdata,
    input  logic [2:0]                        fault_set,
    output logic [AW-1:0]                     cfg_rdata,
    output logic                              prot_en,
    output logic [1:0]                        cur_set,
    output logic [2:0]                        sticky,
    output logic [ND-1:0]                     d_rd,
    output logic [ND-1:0]                     d_wr,
    output logic [NC-1:0]                     c_ex,
    output logic [N_SETS-1:0][N_DPAIR-1:0]    dsel,
    output logic [N_SETS-1:0][N_CPAIR-1:0]    csel,
    output logic [ND-1:0][BW-1:0]             d_lo,
    output logic [ND-1:0][BW-1:0]             d_hi,
    output logic [NC-1:0][BW-1:0]             c_lo,
    output logic [NC-1:0][BW-1:0]             c_hi
);
    typedef struct packed {
        logic                           en;
        logic [1:0]                     set;
        logic [2:0]                     sticky;
        logic [ND-1:0]                  rd;
        logic [ND-1:0]                  wr;
        logic [NC-1:0]                  ex;
        logic [N_SETS-1:0][N_DPAIR-1:0] dsel;
        logic [N_SETS-1:0][N_CPAIR-1:0] csel;
        logic [ND-1:0][BW-1:0]          dlo;
        logic [ND-1:0][BW-1:0]          dhi;
        logic [NC-1:0][BW-1:0]          clo;
        logic [NC-1:0][BW-1:0]          chi;
    } regs_t;

    regs_t r_d, r_q;
    logic [2:0] clr_bits;

    always_comb begin
        r_d      = r_q;
        clr_bits = (cfg_we && cfg_addr == REG_FSTAT) ? cfg_wdata[2:0] : 3'b000;
        // a fresh fault outranks a clear landing in the same cycle
        r_d.sticky = (r_q.sticky & ~clr_bits) | fault_set;
        if (cfg_we) begin
            if (cfg_addr == REG_CTRL) begin
                r_d.en = cfg_wdata[0];
                if (int'(cfg_wdata[2:1]) < N_SETS) begin
                    r_d.set = cfg_wdata[2:1];
                end
            end
            if (cfg_addr == REG_DPERM) begin
                for (int i = 0; i < ND; i++) begin
                    r_d.rd[i] = cfg_wdata[2*i];
                    r_d.wr[i] = cfg_wdata[2*i+1];
                end
            end
            if (cfg_addr == REG_XPERM) begin
                r_d.ex = cfg_wdata[NC-1:0];
            end
            for (int s = 0; s < N_SETS; s++) begin
                if (cfg_addr == REG_SEL_BASE + 7'(s)) begin
                    r_d.dsel[s] = cfg_wdata[N_DPAIR-1:0];
                    r_d.csel[s] = cfg_wdata[8 +: N_CPAIR];
                end
            end
            for (int i = 0; i < ND; i++) begin
                if (cfg_addr == REG_DRNG_BASE + 7'(2*i))   r_d.dlo[i] = cfg_wdata[AW-1:GRAN_BITS];
                if (cfg_addr == REG_DRNG_BASE + 7'(2*i+1)) r_d.dhi[i] = cfg_wdata[AW-1:GRAN_BITS];
            end
            for (int i = 0; i < NC; i++) begin
                if (cfg_addr == REG_CRNG_BASE + 7'(2*i))   r_d.clo[i] = cfg_wdata[AW-1:GRAN_BITS];
                if (cfg_addr == REG_CRNG_BASE + 7'(2*i+1)) r_d.chi[i] = cfg_wdata[AW-1:GRAN_BITS];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    always_comb begin
        cfg_rdata = '0;
        if (cfg_addr == REG_CTRL)  cfg_rdata[2:0] = {r_q.set, r_q.en};
        if (cfg_addr == REG_FSTAT) cfg_rdata[2:0] = r_q.sticky;
        if (cfg_addr == REG_DPERM) begin
            for (int i = 0; i < ND; i++) begin
                cfg_rdata[2*i]   = r_q.rd[i];
                cfg_rdata[2*i+1] = r_q.wr[i];
            end
        end
        if (cfg_addr == REG_XPERM) cfg_rdata[NC-1:0] = r_q.ex;
        for (int s = 0; s < N_SETS; s++) begin
            if (cfg_addr == REG_SEL_BASE + 7'(s)) begin
                cfg_rdata[N_DPAIR-1:0] = r_q.dsel[s];
                cfg_rdata[8 +: N_CPAIR] = r_q.csel[s];
            end
        end
        for (int i = 0; i < ND; i++) begin
            if (cfg_addr == REG_DRNG_BASE + 7'(2*i))   cfg_rdata = {r_q.dlo[i], {GRAN_BITS{1'b0}}};
            if (cfg_addr == REG_DRNG_BASE + 7'(2*i+1)) cfg_rdata = {r_q.dhi[i], {GRAN_BITS{1'b0}}};
        end
        for (int i = 0; i < NC; i++) begin
            if (cfg_addr == REG_CRNG_BASE + 7'(2*i))   cfg_rdata = {r_q.clo[i], {GRAN_BITS{1'b0}}};
            if (cfg_addr == REG_CRNG_BASE + 7'(2*i+1)) cfg_rdata = {r_q.chi[i], {GRAN_BITS{1'b0}}};
        end
    end

    assign prot_en = r_q.en;
    assign cur_set = r_q.set;
    assign sticky  = r_q.sticky;
    assign d_rd    = r_q.rd;
    assign d_wr    = r_q.wr;
    assign c_ex    = r_q.ex;
    assign dsel    = r_q.dsel;
    assign csel    = r_q.csel;
    assign d_lo    = r_q.dlo;
    assign d_hi    = r_q.dhi;
    assign c_lo    = r_q.clo;
    assign c_hi    = r_q.chi;
endmodule

// File: rtl/mpu_decide.sv
module mpu_decide
    import mpu_pkg::*;
#(
    parameter int AW      = 32,
    parameter int N_DPAIR = 2,
    parameter int N_CPAIR = 2,
    parameter int N_SETS  = 2,
    localparam int ND     = 2 * N_DPAIR,
    localparam int NC     = 2 * N_CPAIR,
    localparam int BW     = AW - GRAN_BITS
) (
    input  logic [AW-1:0]                  addr,
    input  logic [1:0]                     kind,
    input  logic                           ctx,
    input  logic                           prot_en,
    input  logic [1:0]                     cur_set,
    input  logic [ND-1:0]                  d_rd,
    input  logic [ND-1:0]                  d_wr,
    input  logic [NC-1:0]                  c_ex,
    input  logic [N_SETS-1:0][N_DPAIR-1:0] dsel,
    input  logic [N_SETS-1:0][N_CPAIR-1:0] csel,
    input  logic [ND-1:0][BW-1:0]          d_lo,
    input  logic [ND-1:0][BW-1:0]          d_hi,
    input  logic [NC-1:0][BW-1:0]          c_lo,
    input  logic [NC-1:0][BW-1:0]          c_hi,
    output logic                           permit
);
    logic [ND-1:0]      d_hit, d_live;
    logic [NC-1:0]      c_hit, c_live;
    logic [N_DPAIR-1:0] dsel_cur;
    logic [N_CPAIR-1:0] csel_cur;
    logic               exempt, rd_ok, wr_ok, ex_ok;

    for (genvar g = 0; g < ND; g++) begin : g_dwin
        mpu_window_cmp #(.AW(AW)) u_cmp (
            .addr (addr),
            .lo   ({d_lo[g], {GRAN_BITS{1'b0}}}),
            .hi   ({d_hi[g], {GRAN_BITS{1'b0}}}),
            .hit  (d_hit[g])
        );
    end

    for (genvar g = 0; g < NC; g++) begin : g_cwin
        mpu_window_cmp #(.AW(AW)) u_cmp (
            .addr (addr),
            .lo   ({c_lo[g], {GRAN_BITS{1'b0}}}),
            .hi   ({c_hi[g], {GRAN_BITS{1'b0}}}),
            .hit  (c_hit[g])
        );
    end

    always_comb begin
        dsel_cur = '0;
        csel_cur = '0;
        for (int s = 0; s < N_SETS; s++) begin
            if (cur_set == 2'(s)) begin
                dsel_cur = dsel[s];
                csel_cur = csel[s];
            end
        end
        for (int p = 0; p < N_DPAIR; p++) begin
            d_live[2*p]   = d_hit[2*p]   & ~dsel_cur[p];
            d_live[2*p+1] = d_hit[2*p+1] &  dsel_cur[p];
        end
        for (int p = 0; p < N_CPAIR; p++) begin
            c_live[2*p]   = c_hit[2*p]   & ~csel_cur[p];
            c_live[2*p+1] = c_hit[2*p+1] &  csel_cur[p];
        end
        // any live covering window that grants the type is enough
        rd_ok  = |(d_live & d_rd);
        wr_ok  = |(d_live & d_wr);
        ex_ok  = |(c_live & c_ex);
        exempt = ctx || (addr[AW-1 -: 4] == SEG_PERIPH) || (addr[AW-1 -: 4] == SEG_EMU);
        if (!prot_en || exempt)   permit = 1'b1;
        else if (kind == KIND_EX) permit = ex_ok;
        else if (kind == KIND_WR) permit = wr_ok;
        else                      permit = rd_ok;
    end
endmodule

// File: rtl/mpu_range_check.sv
module mpu_range_check
    import mpu_pkg::*;
#(
    parameter int AW      = 32,
    parameter int N_DPAIR = 2,
    parameter int N_CPAIR = 2,
    parameter int N_SETS  = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              acc_valid,
    input  logic [AW-1:0]     acc_addr,
    input  logic [1:0]        acc_kind,
    input  logic              acc_ctx,
    input  logic              cfg_we,
    input  logic [CFG_AW-1:0] cfg_addr,
    input  logic [AW-1:0]     cfg_wdata,
    output logic [AW-1:0]     cfg_rdata,
    output logic              chk_valid,
    output logic              chk_permit,
    output logic              chk_fault,
    output logic [1:0]        chk_fault_kind
);
    localparam int ND = 2 * N_DPAIR;
    localparam int NC = 2 * N_CPAIR;
    localparam int BW = AW - GRAN_BITS;

    typedef struct packed {
        logic       vld;
        logic       permit;
        logic       fault;
        logic [1:0] kind;
    } verdict_t;

    logic                           prot_en;
    logic [1:0]                     cur_set;
    logic [2:0]                     sticky;
    logic [ND-1:0]                  d_rd, d_wr;
    logic [NC-1:0]                  c_ex;
    logic [N_SETS-1:0][N_DPAIR-1:0] dsel;
    logic [N_SETS-1:0][N_CPAIR-1:0] csel;
    logic [ND-1:0][BW-1:0]          d_lo, d_hi;
    logic [NC-1:0][BW-1:0]          c_lo, c_hi;
    logic                           permit_now, deny;
    logic [1:0]                     kind_n;
    logic [2:0]                     fault_set;
    verdict_t                       v_d, v_q;

    mpu_cfg_regs #(.AW(AW), .N_DPAIR(N_DPAIR), .N_CPAIR(N_CPAIR), .N_SETS(N_SETS)) u_regs (
        .clk, .rst_n, .cfg_we, .cfg_addr, .cfg_wdata, .fault_set, .cfg_rdata,
        .prot_en, .cur_set, .sticky, .d_rd, .d_wr, .c_ex, .dsel, .csel,
        .d_lo, .d_hi, .c_lo, .c_hi
    );

    mpu_decide #(.AW(AW), .N_DPAIR(N_DPAIR), .N_CPAIR(N_CPAIR), .N_SETS(N_SETS)) u_decide (
        .addr (acc_addr), .kind (kind_n), .ctx (acc_ctx), .prot_en, .cur_set,
        .d_rd, .d_wr, .c_ex, .dsel, .csel, .d_lo, .d_hi, .c_lo, .c_hi,
        .permit (permit_now)
    );

    always_comb begin
        kind_n       = (acc_kind == KIND_RSV) ? KIND_RD : acc_kind;
        deny         = acc_valid && !permit_now;
        fault_set[0] = deny && (kind_n == KIND_RD);
        fault_set[1] = deny && (kind_n == KIND_WR);
        fault_set[2] = deny && (kind_n == KIND_EX);
        v_d.vld      = acc_valid;
        v_d.permit   = acc_valid && permit_now;
        v_d.fault    = deny;
        v_d.kind     = deny ? kind_n : 2'b00;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) v_q <= '0;
        else        v_q <= v_d;
    end

    assign chk_valid      = v_q.vld;
    assign chk_permit     = v_q.permit;
    assign chk_fault      = v_q.fault;
    assign chk_fault_kind = v_q.kind;
endmodule

// File: rtl/mpu_range_check_sva.sv
module mpu_range_check_sva (
    input logic       clk,
    input logic       rst_n,
    input logic       acc_valid,
    input logic [3:0] acc_seg,
    input logic       acc_ctx,
    input logic       clr_we,
    input logic [2:0] clr_bits,
    input logic       prot_en,
    input logic [2:0] sticky,
    input logic       chk_valid,
    input logic       chk_permit,
    input logic       chk_fault,
    input logic [1:0] chk_fault_kind
);
    a_r8_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        acc_valid |=> chk_valid);
    a_r8_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !acc_valid |=> (!chk_valid && !chk_fault));
    a_r7_disabled: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && !prot_en) |=> chk_permit);
    a_r6_ctx: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && acc_ctx) |=> chk_permit);
    a_r6_segment: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && (acc_seg == 4'hF || acc_seg == 4'hE)) |=> chk_permit);
    a_r9_capture_ex: assert property (@(posedge clk) disable iff (!rst_n)
        (chk_fault && chk_fault_kind == 2'd2) |-> sticky[2]);
    a_r9_capture_rd: assert property (@(posedge clk) disable iff (!rst_n)
        (chk_fault && chk_fault_kind == 2'd0) |-> sticky[0]);
    a_r9_hold: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(sticky[0]) |-> $past(clr_we && clr_bits[0]));
endmodule

bind mpu_range_check mpu_range_check_sva u_sva (
    .clk            (clk),
    .rst_n          (rst_n),
    .acc_valid      (acc_valid),
    .acc_seg        (acc_addr[AW-1 -: 4]),
    .acc_ctx        (acc_ctx),
    .clr_we         (cfg_we && cfg_addr == 7'h01),
    .clr_bits       (cfg_wdata[2:0]),
    .prot_en        (prot_en),
    .sticky         (sticky),
    .chk_valid      (chk_valid),
    .chk_permit     (chk_permit),
    .chk_fault      (chk_fault),
    .chk_fault_kind (chk_fault_kind)
);

// File: tb/mpu_range_check_tb.sv
`timescale 1ns/1ps
module mpu_range_check_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        acc_valid = 1'b0;
    logic [31:0] acc_addr = '0;
    logic [1:0]  acc_kind = '0;
    logic        acc_ctx = 1'b0;
    logic        cfg_we = 1'b0;
    logic [6:0]  cfg_addr = '0;
    logic [31:0] cfg_wdata = '0;
    logic [31:0] cfg_rdata;
    logic        chk_valid, chk_permit, chk_fault;
    logic [1:0]  chk_fault_kind;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    // bench copy of what was programmed
    logic [31:0] sh_dlo [4], sh_dhi [4], sh_clo [4], sh_chi [4];
    logic [3:0]  sh_rd, sh_wr, sh_ex;
    logic [1:0]  sh_dsel [2], sh_csel [2];
    logic        sh_en;
    int          sh_cur;

    always #2 clk = ~clk;

    mpu_range_check u_dut (
        .clk, .rst_n, .acc_valid, .acc_addr, .acc_kind, .acc_ctx,
        .cfg_we, .cfg_addr, .cfg_wdata, .cfg_rdata,
        .chk_valid, .chk_permit, .chk_fault, .chk_fault_kind
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic cfg_write(input logic [6:0] a, input logic [31:0] d);
        @(negedge clk);
        cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic cfg_read(input logic [6:0] a, output logic [31:0] d);
        @(negedge clk);
        cfg_addr = a;
        #1 d = cfg_rdata;
    endtask

    function automatic logic expect_permit(input logic [31:0] a, input int k, input logic ctx);
        logic ok;
        int   i;
        ok = 1'b0;
        if (!sh_en || ctx || a[31:28] == 4'hF || a[31:28] == 4'hE) return 1'b1;
        for (int p = 0; p < 2; p++) begin
            i = 2*p + int'(sh_dsel[sh_cur][p]);
            if (a >= sh_dlo[i] && a < sh_dhi[i]) begin
                if (k == 1) ok |= sh_wr[i];
                else if (k != 2) ok |= sh_rd[i];
            end
            i = 2*p + int'(sh_csel[sh_cur][p]);
            if (k == 2 && a >= sh_clo[i] && a < sh_chi[i]) ok |= sh_ex[i];
        end
        return ok;
    endfunction

    task automatic do_access(input logic [31:0] a, input int k, input logic ctx, input string req);
        logic       p;
        logic [1:0] kn;
        p  = expect_permit(a, k, ctx);
        kn = (k == 3) ? 2'd0 : 2'(k);
        @(negedge clk);
        acc_valid = 1'b1; acc_addr = a; acc_kind = 2'(k); acc_ctx = ctx;
        @(negedge clk);
        acc_valid = 1'b0; acc_ctx = 1'b0;
        chk(req, {27'b0, chk_valid, chk_permit, chk_fault, chk_fault_kind},
                 {27'b0, 1'b1, p, !p, (p ? 2'd0 : kn)});
    endtask

    task automatic set_dwin(input int i, input logic [31:0] lo, input logic [31:0] hi);
        cfg_write(7'h20 + 7'(2*i), lo); cfg_write(7'h21 + 7'(2*i), hi);
        sh_dlo[i] = lo & ~32'h7; sh_dhi[i] = hi & ~32'h7;
    endtask

    task automatic set_cwin(input int i, input logic [31:0] lo, input logic [31:0] hi);
        cfg_write(7'h40 + 7'(2*i), lo); cfg_write(7'h41 + 7'(2*i), hi);
        sh_clo[i] = lo & ~32'h7; sh_chi[i] = hi & ~32'h7;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [31:0] rd;
        for (int i = 0; i < 4; i++) begin
            sh_dlo[i] = 0; sh_dhi[i] = 0; sh_clo[i] = 0; sh_chi[i] = 0;
        end
        sh_rd = 0; sh_wr = 0; sh_ex = 0; sh_en = 0; sh_cur = 0;
        sh_dsel[0] = 0; sh_dsel[1] = 0; sh_csel[0] = 0; sh_csel[1] = 0;

        repeat (3) @(negedge clk);
        // R10: reset state
        chk("R10 outputs", {28'b0, chk_valid, chk_permit, chk_fault, chk_fault_kind[0]}, 32'h0);
        rst_n = 1'b1;
        cfg_read(7'h00, rd); chk("R10 control", rd, 32'h0);
        cfg_read(7'h01, rd); chk("R10 status", rd, 32'h0);
        cfg_read(7'h21, rd); chk("R10 bound", rd, 32'h0);
        do_access(32'h100, 2, 1'b0, "R10/R7 off after reset");

        // R1 granularity and R11 map
        set_dwin(0, 32'h045, 32'h100);
        cfg_read(7'h20, rd); chk("R1 low bits dropped", rd, 32'h040);
        set_dwin(1, 32'h080, 32'h140);
        set_dwin(2, 32'h0C0, 32'h180);
        set_dwin(3, 32'h000, 32'h020);
        set_cwin(0, 32'h100, 32'h180);
        set_cwin(1, 32'h000, 32'h0C0);
        set_cwin(2, 32'h180, 32'h1F8);
        set_cwin(3, 32'h0A0, 32'h0E0);
        cfg_write(7'h02, 32'h6D); sh_rd = 4'b1011; sh_wr = 4'b0110;
        cfg_write(7'h03, 32'h7);  sh_ex = 4'b0111;
        cfg_write(7'h08, 32'h200); sh_dsel[0] = 2'b00; sh_csel[0] = 2'b10;
        cfg_write(7'h09, 32'h103); sh_dsel[1] = 2'b11; sh_csel[1] = 2'b01;
        cfg_read(7'h02, rd); chk("R11 rights readback", rd, 32'h6D);
        cfg_read(7'h08, rd); chk("R11 select readback", rd, 32'h200);

        // R7: disabled permits everything
        for (int a = 0; a < 'h200; a += 24) do_access(32'(a), 1, 1'b0, "R7 disabled");

        // R1 R2 R3 R4 R5 sweep over both sets and all kinds
        for (int s = 0; s < 2; s++) begin
            cfg_write(7'h00, {29'b0, 2'(s), 1'b1}); sh_en = 1'b1; sh_cur = s;
            for (int k = 0; k < 4; k++)
                for (int a = 0; a < 'h200; a += 4)
                    do_access(32'(a), k, 1'b0, "R1/R2/R3/R4/R5 sweep");
        end

        // R2: out-of-range set number ignored (current set stays 1)
        cfg_write(7'h00, 32'h7);
        cfg_read(7'h00, rd); chk("R2 set guard", rd, 32'h3);

        // R6 exemptions, set 0
        cfg_write(7'h00, 32'h1); sh_cur = 0;
        do_access(32'hF000_0010, 2, 1'b0, "R6 peripheral");
        do_access(32'hE000_0000, 1, 1'b0, "R6 emulator");
        do_access(32'hD000_0000, 0, 1'b0, "R4 other segment");
        do_access(32'h1F0, 1, 1'b1, "R6 context save");

        // R9 sticky status
        cfg_write(7'h01, 32'h7);
        cfg_read(7'h01, rd); chk("R9 cleared", rd, 32'h0);
        do_access(32'h1F0, 0, 1'b0, "R8 read fault");
        cfg_read(7'h01, rd); chk("R9 read bit", rd, 32'h1);
        // fault and clear in the same cycle
        @(negedge clk);
        cfg_we = 1'b1; cfg_addr = 7'h01; cfg_wdata = 32'h1;
        acc_valid = 1'b1; acc_addr = 32'h1F0; acc_kind = 2'd2;
        @(negedge clk);
        cfg_we = 1'b0; acc_valid = 1'b0;
        chk("R8 exec fault kind", {30'b0, chk_fault_kind}, 32'h2);
        cfg_read(7'h01, rd); chk("R9 set beats clear", rd, 32'h4);
        @(negedge clk);
        chk("R8 idle", {30'b0, chk_valid, chk_fault}, 32'h0);
        do_access(32'h1F0, 1, 1'b0, "R8 write fault");
        cfg_read(7'h01, rd); chk("R9 write bit", rd, 32'h6);
        cfg_write(7'h01, 32'h2);
        cfg_read(7'h01, rd); chk("R9 partial clear", rd, 32'h4);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule